// File: doc/BRIEF.md
# Key-Protected Pin Function Guard

This block holds the function-select state of one general-purpose port and keeps a group of protected pins on that port in their debug-port function unless software goes through a deliberate release sequence. Out of reset the protected pins select their alternate (debug) function with the digital path enabled. To hand one of them over to general-purpose use, software must take three steps in order. First it writes a 32-bit key to the lock register. It then sets that pin's bit in the commit register. Only after that does it rewrite the alternate-function and digital-enable registers.

Any write of a value other than the key to the lock register closes the port again. The commit bits keep their values across a relock but cannot be changed until the next unlock. Pins outside the protected group are never guarded. Register access needs the port clock: software raises the port clock-enable input and waits for the ready output before touching the registers. Accesses made before the port is ready read as zero and change nothing.

Top module: `pin_func_guard`

## Requirements
- R1: After reset, every protected pin (default mask 0x0F on an 8-pin port) drives alternate-select 1 and digital-enable 1, and every unprotected pin drives 0 on both. The lock register (word address 0x2) reads 1 and the commit register (word address 0x3) reads 0.
- R2: The ready output rises READY_DLY clock edges (default 2) after the clock-enable input goes high. It drops in the same cycle that the clock-enable input goes low.
- R3: While ready is low, every read returns 0 and every write leaves all registers and pin outputs unchanged.
- R4: A write of 0x4C4F434B to the lock register unlocks the port. The lock register then reads 0x0.
- R5: A write of any other 32-bit value to the lock register, including values one bit away from the key, locks the port. The lock register then reads 0x1.
- R6: A write to the commit register stores write-data bits NPINS-1:0 only while the port is unlocked. It is ignored while the port is locked. The commit register reads back its bits in the low positions.
- R7: A write to the alternate-select register (word address 0x0) or the digital-enable register (word address 0x1) updates pin i from write-data bit i. For a protected pin, this happens only if its commit bit is 1. Unprotected pins are always updated. Each register reads back the pin values in its low bits.
- R8: Relocking leaves the commit bits unchanged.
- R9: Reads of unmapped word addresses (0x4 to 0xF) return 0, and all bits above the mapped fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portClkEn | input | 1 | Port clock enable |
| portReady | output | 1 | Port registers accessible |
| busAddr | input | 4 | Register word address |
| busWe | input | 1 | Write enable, single cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| pinAltSel | output | NPINS | Per-pin alternate-function select (1 = debug/alternate) |
| pinDigEn | output | NPINS | Per-pin digital enable |

## Verification
The hardest state to reach is a protected pin whose commit bit was set during an earlier unlock window, with the port since relocked, while a function-select write arrives. Reaching it takes a full unlock, commit, relock and write sequence. The stimulus therefore walks all 256 commit patterns through exactly that sequence. Each pass relocks with a value one bit away from the key and then writes alternate-select and digital-enable patterns. The pin states are compared against masks computed from the commit value. A second pass drops and restores the clock enable and writes in the not-yet-ready window.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h4C4F_434B;

  localparam logic [ADDR_W-1:0] A_ALTSEL = 4'h0;
  localparam logic [ADDR_W-1:0] A_DIGEN  = 4'h1;
  localparam logic [ADDR_W-1:0] A_LOCK   = 4'h2;
  localparam logic [ADDR_W-1:0] A_COMMIT = 4'h3;

  // strobes from control to datapath
  typedef struct packed {
    logic access;  // port ready, register bus live
    logic wrAlt;   // write to alternate-select register
    logic wrDig;   // write to digital-enable register
  } pfgStrobes_t;
endpackage

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
#(
  parameter int unsigned NPINS     = 8,
  parameter logic [NPINS-1:0] PROT_MASK = 8'h0F,
  parameter int unsigned READY_DLY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portClkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic              portReady,
  output logic              unlocked,
  output logic [NPINS-1:0]  commitBits,
  output logic [NPINS-1:0]  wrMask,
  output pfgStrobes_t       strobes
);
  localparam int unsigned DLY   = (READY_DLY < 1) ? 1 : READY_DLY;
  localparam int unsigned CNT_W = $clog2(DLY + 1);

  logic [CNT_W-1:0] readyCnt;
  logic             wrLive;

  // ready counter restarts whenever the port clock is gated off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               readyCnt <= '0;
    else if (!portClkEn)                     readyCnt <= '0;
    else if (readyCnt != CNT_W'(DLY))        readyCnt <= readyCnt + 1'b1;
  end

  assign portReady = portClkEn && (readyCnt == CNT_W'(DLY));
  assign wrLive    = portReady && busWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked   <= 1'b0;
      commitBits <= '0;
    end else begin
      if (wrLive && busAddr == A_LOCK)
        unlocked <= (busWdata == UNLOCK_KEY);
      if (wrLive && busAddr == A_COMMIT && unlocked)
        commitBits <= busWdata[NPINS-1:0];
    end
  end

  assign wrMask         = ~PROT_MASK | commitBits;
  assign strobes.access = portReady;
  assign strobes.wrAlt  = wrLive && (busAddr == A_ALTSEL);
  assign strobes.wrDig  = wrLive && (busAddr == A_DIGEN);
endmodule

// File: rtl/pfg_datapath.sv
module pfg_datapath
  import pfg_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter logic [NPINS-1:0] PROT_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfgStrobes_t       strobes,
  input  logic [NPINS-1:0]  wrMask,
  input  logic [NPINS-1:0]  wrBits,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              unlocked,
  input  logic [NPINS-1:0]  commitBits,
  output logic [NPINS-1:0]  pinAltSel,
  output logic [NPINS-1:0]  pinDigEn,
  output logic [BUS_W-1:0]  busRdata
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinAltSel[i] <= PROT_MASK[i];
        pinDigEn[i]  <= PROT_MASK[i];
      end else begin
        if (strobes.wrAlt && wrMask[i]) pinAltSel[i] <= wrBits[i];
        if (strobes.wrDig && wrMask[i]) pinDigEn[i]  <= wrBits[i];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobes.access) begin
      unique case (busAddr)
        A_ALTSEL: busRdata[NPINS-1:0] = pinAltSel;
        A_DIGEN:  busRdata[NPINS-1:0] = pinDigEn;
        A_LOCK:   busRdata[0]         = ~unlocked;
        A_COMMIT: busRdata[NPINS-1:0] = commitBits;
        default:  busRdata            = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_func_guard.sv
module pin_func_guard
  import pfg_pkg::*;
#(
  parameter int unsigned NPINS     = 8,
  parameter logic [NPINS-1:0] PROT_MASK = 8'h0F,
  parameter int unsigned READY_DLY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portClkEn,
  output logic              portReady,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic [NPINS-1:0]  pinAltSel,
  output logic [NPINS-1:0]  pinDigEn
);
  logic             unlocked;
  logic [NPINS-1:0] commitBits;
  logic [NPINS-1:0] wrMask;
  pfgStrobes_t      strobes;

  pfg_ctrl #(.NPINS(NPINS), .PROT_MASK(PROT_MASK), .READY_DLY(READY_DLY)) i_ctrl (
    .clk(clk), .rstN(rstN), .portClkEn(portClkEn),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .portReady(portReady), .unlocked(unlocked), .commitBits(commitBits),
    .wrMask(wrMask), .strobes(strobes)
  );

  pfg_datapath #(.NPINS(NPINS), .PROT_MASK(PROT_MASK)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrMask(wrMask),
    .wrBits(busWdata[NPINS-1:0]), .busAddr(busAddr),
    .unlocked(unlocked), .commitBits(commitBits),
    .pinAltSel(pinAltSel), .pinDigEn(pinDigEn), .busRdata(busRdata)
  );
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker
  import pfg_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter logic [NPINS-1:0] PROT_MASK = 8'h0F
) (
  input logic              clk,
  input logic              rstN,
  input logic              portClkEn,
  input logic              portReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [BUS_W-1:0]  busWdata,
  input logic [BUS_W-1:0]  busRdata,
  input logic [NPINS-1:0]  pinAltSel,
  input logic [NPINS-1:0]  pinDigEn,
  input logic              unlocked,
  input logic [NPINS-1:0]  commitBits
);
  a_r2_ready_needs_clk: assert property (@(posedge clk) disable iff (!rstN)
    portReady |-> portClkEn);

  a_r3_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !portReady |-> busRdata == '0);

  a_r3_idle_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    !portReady |=> $stable(pinAltSel) && $stable(pinDigEn) &&
                   $stable(commitBits) && $stable(unlocked));

  a_r4_key_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (portReady && busWe && busAddr == A_LOCK && busWdata == UNLOCK_KEY) |=> unlocked);

  a_r5_other_relocks: assert property (@(posedge clk) disable iff (!rstN)
    (portReady && busWe && busAddr == A_LOCK && busWdata != UNLOCK_KEY) |=> !unlocked);

  a_r4_lock_readback: assert property (@(posedge clk) disable iff (!rstN)
    (portReady && busAddr == A_LOCK) |-> busRdata == {31'b0, !unlocked});

  a_r6_commit_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(commitBits));

  a_r7_alt_guarded: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pinAltSel ^ $past(pinAltSel)) & PROT_MASK & ~$past(commitBits)) == '0);

  a_r7_dig_guarded: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pinDigEn ^ $past(pinDigEn)) & PROT_MASK & ~$past(commitBits)) == '0);
endmodule

bind pin_func_guard pfg_checker #(.NPINS(NPINS), .PROT_MASK(PROT_MASK)) u_pfgChecker (
  .clk(clk), .rstN(rstN), .portClkEn(portClkEn), .portReady(portReady),
  .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
  .pinAltSel(pinAltSel), .pinDigEn(pinDigEn),
  .unlocked(unlocked), .commitBits(commitBits)
);

// File: tb/test_pin_func_guard.sv
module test_pin_func_guard;
  import pfg_pkg::*;

  localparam logic [7:0] PROT = 8'h0F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portClkEn = 1'b0;
  logic        portReady;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pinAltSel;
  logic [7:0]  pinDigEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // specification model
  logic [7:0] altM, digM, commitM;
  bit         unlockedM, expReady;

  always #5 clk = ~clk;

  pin_func_guard #(.NPINS(8), .PROT_MASK(PROT), .READY_DLY(2)) i_pin_func_guard (
    .clk(clk), .rstN(rstN), .portClkEn(portClkEn), .portReady(portReady),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .pinAltSel(pinAltSel), .pinDigEn(pinDigEn)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    logic [7:0] allow;
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    if (expReady) begin
      allow = commitM | ~PROT;
      case (a)
        A_ALTSEL: altM = (altM & ~allow) | (d[7:0] & allow);
        A_DIGEN:  digM = (digM & ~allow) | (d[7:0] & allow);
        A_LOCK:   unlockedM = (d == UNLOCK_KEY);
        A_COMMIT: if (unlockedM) commitM = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic rdChk(string tag, logic [3:0] a);
    logic [31:0] e;
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1;
    e = '0;
    if (expReady) begin
      case (a)
        A_ALTSEL: e = {24'b0, altM};
        A_DIGEN:  e = {24'b0, digM};
        A_LOCK:   e = {31'b0, !unlockedM};
        A_COMMIT: e = {24'b0, commitM};
        default:  e = '0;
      endcase
    end
    chk(tag, busRdata, e);
  endtask

  task automatic pinsChk(string tag);
    #1;
    chk({tag, " alt"}, {24'b0, pinAltSel}, {24'b0, altM});
    chk({tag, " dig"}, {24'b0, pinDigEn}, {24'b0, digM});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    altM = PROT; digM = PROT; commitM = '0; unlockedM = 0; expReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state; R3 reads zero while not ready
    pinsChk("R1 reset");
    chk("R2 ready low without clk", {31'b0, portReady}, 32'd0);
    rdChk("R3 lock read before ready", A_LOCK);
    wr(A_LOCK, UNLOCK_KEY);  // R3: ignored
    rdChk("R3 lock write ignored idle", A_LOCK);

    // R2 ready timing
    @(negedge clk); portClkEn = 1'b1;
    @(negedge clk); #1 chk("R2 ready after one edge", {31'b0, portReady}, 32'd0);
    @(negedge clk); #1 chk("R2 ready after two edges", {31'b0, portReady}, 32'd1);
    expReady = 1;

    rdChk("R1 lock reads 1", A_LOCK);
    rdChk("R1 commit reads 0", A_COMMIT);
    rdChk("R1 alt readback", A_ALTSEL);
    rdChk("R1 dig readback", A_DIGEN);

    // R7 guarded while uncommitted, R6 commit ignored while locked
    wr(A_ALTSEL, 32'h0000_0050);
    pinsChk("R7 uncommitted alt write");
    wr(A_COMMIT, 32'hFF);
    rdChk("R6 commit locked ignored", A_COMMIT);

    // R9 unmapped addresses
    for (int a = 4; a < 16; a++) rdChk("R9 unmapped read", 4'(a));

    // sweep every commit pattern
    for (int c = 0; c < 256; c++) begin
      logic [31:0] relockVal;
      logic [7:0]  p;
      relockVal = UNLOCK_KEY ^ (32'h1 << (c % 32));
      p = 8'(c * 37 + 5);
      wr(A_LOCK, UNLOCK_KEY);
      rdChk("R4 lock reads 0 after key", A_LOCK);
      wr(A_COMMIT, {24'hABCDEF, 8'(c)});
      rdChk("R6 commit stored", A_COMMIT);
      wr(A_LOCK, relockVal);
      rdChk("R5 relock near key", A_LOCK);
      rdChk("R8 commit kept on relock", A_COMMIT);
      wr(A_COMMIT, {24'h0, ~8'(c)});
      rdChk("R6 commit blocked after relock", A_COMMIT);
      wr(A_ALTSEL, {24'hFFFFFF, p});
      wr(A_DIGEN, {24'h0, ~p});
      pinsChk("R7 sweep");
      rdChk("R7 alt readback", A_ALTSEL);
      rdChk("R7 dig readback", A_DIGEN);
    end

    // R3 drop the clock: ready falls at once, accesses have no effect
    wr(A_LOCK, UNLOCK_KEY);
    wr(A_COMMIT, 32'h03);
    @(negedge clk); portClkEn = 1'b0; expReady = 0;
    #1 chk("R2 ready falls with clk", {31'b0, portReady}, 32'd0);
    wr(A_ALTSEL, 32'h0);
    wr(A_LOCK, 32'h0);
    wr(A_COMMIT, 32'h0);
    rdChk("R3 read zero while gated", A_ALTSEL);
    pinsChk("R3 pins held while gated");
    @(negedge clk); portClkEn = 1'b1;
    wr(A_DIGEN, 32'h0);  // lands in not-yet-ready window
    expReady = 1;
    rdChk("R3 lock state kept", A_LOCK);
    rdChk("R3 commit kept", A_COMMIT);
    rdChk("R3 dig kept", A_DIGEN);
    pinsChk("R3 pins after restore");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule